// File: doc/BRIEF.md
# Counter/Timer with Clock-Source Select

This block is the 16-bit down-counting counter/timer of a two-channel serial controller. A 3-bit mode field chooses both the kind of operation and the clock that advances the count. The choices are an external input pin, that pin divided by 16, the 1x transmit clock of channel A or of channel B, and the system reference clock with or without a divide-by-16 prescaler. All source clocks are brought into the system clock domain as single-cycle rising-edge enables. Each divide-by-16 is a 4-bit prescaler advanced by those enables.

In timer mode the block reloads the preload value each time the count runs out and flips its output level. The output is a continuous square wave whose half-period is the preload in source ticks. In counter mode a start command loads the preload and the count runs down. When the count reaches zero, the output drops low and stays low until the CPU issues a stop command. The count keeps wrapping through all-ones after terminal count. The output level is never gated by any interrupt mask.

Top module: `uart_ctimer`

## Requirements
- R1: After reset the output is high and the block is idle. No source activity changes the output until a start command.
- R2: Mode codes with bit 2 clear select counter operation. Code 000 counts rising edges of the external pin, 001 counts channel A transmit clock edges, 010 counts channel B transmit clock edges, and 011 counts reference cycles divided by 16. Edges on sources that are not selected have no effect.
- R3: Mode codes with bit 2 set select timer operation. Code 100 uses external pin edges, 101 uses external pin edges divided by 16, 110 uses every reference (system) cycle, and 111 uses reference cycles divided by 16.
- R4: A start command loads the preload, drives the output high, begins counting and clears both prescalers. Start has priority over stop.
- R5: In timer mode the output toggles every max(P,1) source ticks, where P is the preload. Between toggles it holds its level.
- R6: In counter mode the output goes low on the P-th source tick after start, for P ≥ 1 (65536 ticks for P = 0). It stays low while further ticks arrive.
- R7: In counter mode a stop command halts counting and returns the output high. In timer mode a stop command has no effect.
- R8: A start command while counting restarts the count from the preload.
- R9: A divided source yields one tick per 16 rising edges of its base. The first tick comes on the 16th edge after start.
- R10: A source held high produces one tick only. Only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Operation and clock-source code |
| preload | input | 16 | Preload / reload value |
| start_cmd | input | 1 | One-cycle start command strobe |
| stop_cmd | input | 1 | One-cycle stop command strobe |
| ext_pin | input | 1 | External clock input level (asynchronous) |
| txa_clk | input | 1 | Channel A 1x transmit clock level |
| txb_clk | input | 1 | Channel B 1x transmit clock level |
| ct_out | output | 1 | Counter/timer output level |

## Verification
The bench sweeps small preload values in every mode and computes the expected output from the tick count. It goes after the preload 0/1 boundary: a design that reloads at zero instead of one would stretch each half-period by one tick. Prescaler phase is checked cycle by cycle after start, so a prescaler that is not cleared on start, or that counts 15 or 17, misplaces the first divided tick. Stop is applied in both modes: a design that honours stop in timer mode freezes the square wave, and one that ignores it in counter mode keeps the output low. Edges on the unselected transmit clock and long-held pulses expose wrong source decoding and level-instead-of-edge counting.

// File: rtl/uart_ctimer_pkg.sv
// Shared types for the counter/timer.
// Assumes the 3-bit mode code layout below is fixed by the register decoder.
package uart_ctimer_pkg;

    typedef enum logic [2:0] {
        MD_CNT_EXT   = 3'b000,
        MD_CNT_TXA   = 3'b001,
        MD_CNT_TXB   = 3'b010,
        MD_CNT_REF16 = 3'b011,
        MD_TMR_EXT   = 3'b100,
        MD_TMR_EXT16 = 3'b101,
        MD_TMR_REF   = 3'b110,
        MD_TMR_REF16 = 3'b111
    } ct_mode_e;

    // Number of raw clock sources that need edge detection.
    localparam int unsigned NUM_RAW_SRC = 3;
    localparam int unsigned SRC_EXT = 0;
    localparam int unsigned SRC_TXA = 1;
    localparam int unsigned SRC_TXB = 2;

    // Timer operation is selected by the top bit of the mode code.
    function automatic logic is_timer(input logic [2:0] code);
        return code[2];
    endfunction

endpackage

// File: rtl/uart_ctimer_edge.sv
// Rising-edge detector with input synchronizer.
// Assumes SYNC_STAGES >= 2; output is a one-cycle pulse in the clk domain.
module uart_ctimer_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Move the pin level through the synchronizer chain and keep last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // A held-high source yields a single pulse.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/uart_ctimer_presc.sv
// Divide-by-2**PRE_W prescaler driven by a tick enable.
// Assumes clr is the start command; emits tick on the last state when en is high.
module uart_ctimer_presc #(
    parameter int unsigned PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    logic [PRE_W-1:0] cnt_q;

    // Advance on each base enable; restart phase on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

    assign tick = en && (cnt_q == '1);

    // After a divided tick the prescaler is back at its first state.
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_ctimer_srcmux.sv
// Selects the count tick for the current mode code.
// Assumes all inputs are one-cycle enables in the clk domain.
module uart_ctimer_srcmux
    import uart_ctimer_pkg::*;
(
    input  logic [2:0] mode_sel,
    input  logic       ext_en,
    input  logic       ext_div_en,
    input  logic       txa_en,
    input  logic       txb_en,
    input  logic       ref_en,
    input  logic       ref_div_en,
    output logic       tick
);
    // Decode the mode code into a source choice.
    always_comb begin
        unique case (ct_mode_e'(mode_sel))
            MD_CNT_EXT,
            MD_TMR_EXT:    tick = ext_en;
            MD_CNT_TXA:    tick = txa_en;
            MD_CNT_TXB:    tick = txb_en;
            MD_TMR_EXT16:  tick = ext_div_en;
            MD_TMR_REF:    tick = ref_en;
            MD_CNT_REF16,
            MD_TMR_REF16:  tick = ref_div_en;
            default:       tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_ctimer_core.sv
// Down-counter with timer (square wave) and counter (terminal count) behaviour.
// Assumes tick is a one-cycle enable; start wins over stop.
module uart_ctimer_core
    import uart_ctimer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic [CNT_W-1:0] preload,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             tick,
    output logic             out_lvl
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             out_q;
    logic             timer_m;

    assign timer_m = is_timer(mode_sel);

    // Count state, run flag and output level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b1;
        end else if (start_cmd) begin
            cnt_q <= preload;
            run_q <= 1'b1;
            out_q <= 1'b1;
        end else if (stop_cmd && !timer_m) begin
            run_q <= 1'b0;
            out_q <= 1'b1;
        end else if (run_q && tick) begin
            if (timer_m) begin
                if (cnt_q <= ONE) begin
                    cnt_q <= preload;
                    out_q <= ~out_q;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ONE) begin
                    out_q <= 1'b0;
                end
            end
        end
    end

    assign out_lvl = out_q;

    p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> (out_q && run_q && cnt_q == $past(preload)));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start_cmd) |=> (out_q && $stable(cnt_q)));

    p_timer_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_m && !tick && !start_cmd) |=> $stable(out_q));

    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_m && !out_q && !start_cmd && !stop_cmd) |=> !out_q);

    p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !timer_m) |=> out_q);

endmodule

// File: rtl/uart_ctimer.sv
// Counter/timer top: edge detection, prescalers, source select and count core.
// Assumes the system clock is the reference clock; ext_pin may be asynchronous.
module uart_ctimer
    import uart_ctimer_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PRE_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic [CNT_W-1:0] preload,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             ext_pin,
    input  logic             txa_clk,
    input  logic             txb_clk,
    output logic             ct_out
);
    logic [NUM_RAW_SRC-1:0] raw_lvl;
    logic [NUM_RAW_SRC-1:0] raw_rise;
    logic                   ref_en;
    logic                   ext_div_en;
    logic                   ref_div_en;
    logic                   tick;

    assign raw_lvl[SRC_EXT] = ext_pin;
    assign raw_lvl[SRC_TXA] = txa_clk;
    assign raw_lvl[SRC_TXB] = txb_clk;
    assign ref_en           = 1'b1;

    // One edge detector per raw source.
    for (genvar i = 0; i < NUM_RAW_SRC; i++) begin : g_edge
        uart_ctimer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (raw_lvl[i]),
            .rise (raw_rise[i])
        );
    end

    uart_ctimer_presc #(.PRE_W(PRE_W)) u_presc_ext (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_cmd),
        .en   (raw_rise[SRC_EXT]),
        .tick (ext_div_en)
    );

    uart_ctimer_presc #(.PRE_W(PRE_W)) u_presc_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_cmd),
        .en   (ref_en),
        .tick (ref_div_en)
    );

    uart_ctimer_srcmux u_mux (
        .mode_sel  (mode_sel),
        .ext_en    (raw_rise[SRC_EXT]),
        .ext_div_en(ext_div_en),
        .txa_en    (raw_rise[SRC_TXA]),
        .txb_en    (raw_rise[SRC_TXB]),
        .ref_en    (ref_en),
        .ref_div_en(ref_div_en),
        .tick      (tick)
    );

    uart_ctimer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .preload  (preload),
        .start_cmd(start_cmd),
        .stop_cmd (stop_cmd),
        .tick     (tick),
        .out_lvl  (ct_out)
    );

endmodule

// File: tb/uart_ctimer_test.sv
module uart_ctimer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic [15:0] preload = '0;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic        ext_pin = 1'b0;
    logic        txa_clk = 1'b0;
    logic        txb_clk = 1'b0;
    logic        ct_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    uart_ctimer uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .preload(preload),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .ext_pin(ext_pin),
        .txa_clk(txa_clk), .txb_clk(txb_clk), .ct_out(ct_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Start at a negedge; returns at the negedge after the loading edge.
    task automatic do_start(input logic [2:0] md, input int p);
        mode_sel = md;
        preload = 16'(p);
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    // One full pulse on a raw source: 4 cycles high, 4 low (settles the sync).
    task automatic pulse(input int which);
        case (which)
            0: ext_pin = 1'b1;
            1: txa_clk = 1'b1;
            default: txb_clk = 1'b1;
        endcase
        repeat (4) @(negedge clk);
        ext_pin = 1'b0; txa_clk = 1'b0; txb_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: output high after reset, no change without start even in timer mode.
        mode_sel = 3'b110;
        for (int m = 0; m < 12; m++) begin
            chk("R1 idle after reset", ct_out, 1);
            @(negedge clk);
        end
        pulse(0);
        chk("R1 idle ext pulse", ct_out, 1);

        // R3/R5: timer on reference clock, half-period max(P,1) cycles.
        for (int p = 0; p <= 6; p++) begin
            int h;
            h = (p < 1) ? 1 : p;
            do_start(3'b110, p);
            for (int m = 0; m < 20; m++) begin
                chk("R5 timer ref", ct_out, 1 ^ ((m / h) & 1));
                @(negedge clk);
            end
        end

        // R9/R3: timer on reference /16, first tick on 16th cycle after start.
        for (int p = 1; p <= 3; p++) begin
            do_start(3'b111, p);
            for (int m = 0; m < 100; m++) begin
                chk("R9 timer ref16", ct_out, 1 ^ ((m / (16 * p)) & 1));
                @(negedge clk);
            end
        end

        // R2/R6: counter on reference /16 goes low after 16*P cycles.
        for (int p = 1; p <= 4; p++) begin
            do_start(3'b011, p);
            for (int m = 0; m < 80; m++) begin
                chk("R6 counter ref16", ct_out, (m >= 16 * p) ? 0 : 1);
                @(negedge clk);
            end
        end

        // R2/R6: counter on ext pin, and stays low after terminal count.
        for (int p = 1; p <= 5; p++) begin
            do_start(3'b000, p);
            for (int i = 1; i <= p + 2; i++) begin
                pulse(0);
                chk("R6 counter ext", ct_out, (i < p) ? 1 : 0);
            end
        end

        // R2: channel A counts only txa edges; channel B only txb.
        do_start(3'b001, 2);
        pulse(2); pulse(2); pulse(0);
        chk("R2 txa ignores others", ct_out, 1);
        pulse(1);
        chk("R2 txa first", ct_out, 1);
        pulse(1);
        chk("R2 txa tc", ct_out, 0);
        do_start(3'b010, 2);
        pulse(1); pulse(1); pulse(0);
        chk("R2 txb ignores others", ct_out, 1);
        pulse(2); pulse(2);
        chk("R2 txb tc", ct_out, 0);

        // R10: a long-held pulse counts once.
        do_start(3'b000, 2);
        ext_pin = 1'b1;
        repeat (30) @(negedge clk);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 held pin one tick", ct_out, 1);
        pulse(0);
        chk("R10 second edge", ct_out, 0);

        // R3/R5: timer on ext pin, P=2.
        do_start(3'b100, 2);
        for (int i = 1; i <= 8; i++) begin
            pulse(0);
            chk("R5 timer ext", ct_out, 1 ^ ((i / 2) & 1));
        end

        // R9/R3: timer on ext /16, P=1.
        do_start(3'b101, 1);
        for (int i = 1; i <= 34; i++) begin
            pulse(0);
            chk("R9 timer ext16", ct_out, 1 ^ ((i / 16) & 1));
        end

        // R7: stop in timer mode is ignored.
        do_start(3'b110, 3);
        for (int m = 0; m < 20; m++) begin
            chk("R7 timer ignores stop", ct_out, 1 ^ ((m / 3) & 1));
            if (m == 4) begin
                stop_cmd = 1'b1;
                @(negedge clk);
                stop_cmd = 1'b0;
            end else begin
                @(negedge clk);
            end
        end

        // R7: stop in counter mode halts counting.
        do_start(3'b000, 3);
        pulse(0); pulse(0);
        do_stop();
        pulse(0); pulse(0); pulse(0);
        chk("R7 counter halted", ct_out, 1);
        do_start(3'b000, 1);
        pulse(0);
        chk("R7 before stop low", ct_out, 0);
        do_stop();
        chk("R7 stop returns high", ct_out, 1);
        pulse(0); pulse(0);
        chk("R7 stays high after stop", ct_out, 1);

        // R8/R4: start while counting restarts from preload.
        do_start(3'b000, 3);
        pulse(0); pulse(0);
        do_start(3'b000, 3);
        chk("R4 start drives high", ct_out, 1);
        pulse(0); pulse(0);
        chk("R8 restarted not yet", ct_out, 1);
        pulse(0);
        chk("R8 restarted tc", ct_out, 0);
        do_start(3'b000, 2);
        chk("R4 start after tc high", ct_out, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule